// File: doc/BRIEF.md
# Real-Time Clock with Posted Register Writes

This block is a real-time clock that sits on a simple APB-style register bus. Time is kept in a separate slow timekeeping clock domain. A sub-second counter runs up to a configurable divide value and then carries into a seconds counter. Each counter has its own alarm register. When a counting step brings a counter onto its alarm value, the block sets an interrupt status bit. The interrupt output combines those status bits with their enables.

Software never writes the timekeeping registers directly. Each bus write is held in a bus-side shadow and posted across the clock boundary with a toggle request. The register stays busy until the acknowledge toggle comes back through a synchronizer. The status word shows which registers still have a write in flight. A second write to a register that is still busy is dropped, and a sticky error flag records it. Counter values are read through a synchronized, filtered copy.

Top module: `slow_rtc`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is low.
- R2: Control bit 0 lets the sub-second counter count and control bit 1 lets the seconds counter count. While its bit is 0, a counter keeps its value.
- R3: A write to a timekeeping register is posted. It sets status bit 3 (any write pending) and a per-register busy bit: bit 4 sub-second counter, bit 5 seconds counter, bit 6 sub-second alarm, bit 7 seconds alarm, bit 8 control, bit 9 sub-second interrupt clear, bit 10 seconds interrupt clear. The bit stays set until the write has landed and its acknowledge has returned, and then the new value is visible.
- R4: A write to a register whose busy bit is set is discarded, and status bit 2 (write error) sets.
- R5: Any bus write to the status offset 0x14 clears status bit 2.
- R6: The sub-second counter counts 0 to DIV-1 and wraps to 0. On that wrap, if seconds counting is enabled, the seconds counter increments by one. A written sub-second value of DIV or more loads 0.
- R7: Status bit 0 (sub-second) or bit 1 (seconds) sets when a counting step moves that counter onto its alarm value.
- R8: `irq` is high exactly when (status bit 0 and control bit 2) or (status bit 1 and control bit 3).
- R9: A write to offset 0x18 with bit 0 set clears status bit 0, and with bit 1 set clears status bit 1. A bit written as 0 posts nothing. Offset 0x18 reads 0.
- R10: Writes to undefined offsets change nothing, and reads from them return 0.
- R11: Offsets are 0x00 sub-second counter, 0x04 seconds counter, 0x08 sub-second alarm, 0x0C seconds alarm, 0x10 control, 0x14 status and 0x18 interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| tclk | input | 1 | Slow timekeeping clock |
| trstn | input | 1 | Timekeeping-domain reset, active low |
| irq | output | 1 | Interrupt request, bus clock domain |

## Verification
The bench writes the same register twice in quick succession. A design that let the second write through, or that failed to flag it, would read back the later value or show a clear error bit. It also checks that the busy bits land on the right register positions and clear only once the write has taken effect; a wrong bit order or an early clear shows up as stale reads. Alarms are driven through a sub-second wrap into the seconds counter, so a missing carry or a wrong compare never sets status bit 1. Interrupt clears are issued with counting stopped, and the interrupt enables are switched one at a time, so an ungated `irq` or a clear aimed at the wrong bit is visible directly at the output.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_WR = 7;  // posted write slots, in status busy-bit order

  // write slot indices (bit i of status = busy of slot i-4)
  localparam int SLOT_SUB    = 0;
  localparam int SLOT_SEC    = 1;
  localparam int SLOT_SUBALM = 2;
  localparam int SLOT_SECALM = 3;
  localparam int SLOT_CTRL   = 4;
  localparam int SLOT_CLRSUB = 5;
  localparam int SLOT_CLRSEC = 6;

  localparam int OFF_SUB    = 'h00;
  localparam int OFF_SEC    = 'h04;
  localparam int OFF_SUBALM = 'h08;
  localparam int OFF_SECALM = 'h0C;
  localparam int OFF_CTRL   = 'h10;
  localparam int OFF_STAT   = 'h14;
  localparam int OFF_CLR    = 'h18;

  // bus side -> timekeeping side: request toggles plus held shadows
  typedef struct packed {
    logic [NUM_WR-1:0] reqTog;
    logic [DATA_W-1:0] subVal;
    logic [DATA_W-1:0] secVal;
    logic [DATA_W-1:0] subAlm;
    logic [DATA_W-1:0] secAlm;
    logic [3:0]        ctrl;
  } postBus_t;

  // timekeeping side -> bus side
  typedef struct packed {
    logic [NUM_WR-1:0] ackTog;
    logic [DATA_W-1:0] subCnt;
    logic [DATA_W-1:0] secCnt;
    logic [1:0]        intStat;
    logic              irq;
  } timeView_t;
endpackage

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  timeView_t         tkView,
  output postBus_t          post,
  output logic              irq
);
  logic              wrEn;
  logic [NUM_WR-1:0] hit, accept, busyVec;
  logic [NUM_WR-1:0] ackS1, ackS2;
  logic [1:0]        intS1, intS2;
  logic              irqS1, irqS2;
  logic [DATA_W-1:0] subA, subB, secA, secB, subView, secView;
  logic              werr;
  logic              overlap;
  logic              statWr;

  assign wrEn    = psel && penable && pwrite;
  assign busyVec = post.reqTog ^ ackS2;
  assign statWr  = wrEn && (int'(paddr) == OFF_STAT);

  always_comb begin
    hit = '0;
    if (wrEn) begin
      case (int'(paddr))
        OFF_SUB:    hit[SLOT_SUB]    = 1'b1;
        OFF_SEC:    hit[SLOT_SEC]    = 1'b1;
        OFF_SUBALM: hit[SLOT_SUBALM] = 1'b1;
        OFF_SECALM: hit[SLOT_SECALM] = 1'b1;
        OFF_CTRL:   hit[SLOT_CTRL]   = 1'b1;
        OFF_CLR: begin
          hit[SLOT_CLRSUB] = pwdata[0];
          hit[SLOT_CLRSEC] = pwdata[1];
        end
        default: hit = '0;
      endcase
    end
  end

  assign accept  = hit & ~busyVec;
  assign overlap = |(hit & busyVec);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      post    <= '0;
      ackS1   <= '0;
      ackS2   <= '0;
      intS1   <= '0;
      intS2   <= '0;
      irqS1   <= 1'b0;
      irqS2   <= 1'b0;
      subA    <= '0;
      subB    <= '0;
      secA    <= '0;
      secB    <= '0;
      subView <= '0;
      secView <= '0;
      werr    <= 1'b0;
    end else begin
      ackS1 <= tkView.ackTog;
      ackS2 <= ackS1;
      intS1 <= tkView.intStat;
      intS2 <= intS1;
      irqS1 <= tkView.irq;
      irqS2 <= irqS1;
      subA  <= tkView.subCnt;
      subB  <= subA;
      secA  <= tkView.secCnt;
      secB  <= secA;
      if (subA == subB) subView <= subB;
      if (secA == secB) secView <= secB;

      post.reqTog <= post.reqTog ^ accept;
      if (accept[SLOT_SUB])    post.subVal <= pwdata;
      if (accept[SLOT_SEC])    post.secVal <= pwdata;
      if (accept[SLOT_SUBALM]) post.subAlm <= pwdata;
      if (accept[SLOT_SECALM]) post.secAlm <= pwdata;
      if (accept[SLOT_CTRL])   post.ctrl   <= pwdata[3:0];

      if (overlap)     werr <= 1'b1;
      else if (statWr) werr <= 1'b0;
    end
  end

  always_comb begin
    case (int'(paddr))
      OFF_SUB:    prdata = subView;
      OFF_SEC:    prdata = secView;
      OFF_SUBALM: prdata = post.subAlm;
      OFF_SECALM: prdata = post.secAlm;
      OFF_CTRL:   prdata = {28'd0, post.ctrl};
      OFF_STAT:   prdata = {21'd0, busyVec, |busyVec, werr, intS2};
      default:    prdata = '0;
    endcase
  end

  assign irq = irqS2;

  // R4: a write hitting a busy register raises the error flag
  p_overlap_flags_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (|(hit & busyVec)) |=> werr);

  // R5: a write to the status offset leaves the error flag clear
  p_status_write_clears_r5: assert property (@(posedge pclk) disable iff (!presetn)
    statWr |=> !werr);

  // R3: a shadow in flight is not disturbed while its write is pending
  p_shadow_held_r3: assert property (@(posedge pclk) disable iff (!presetn)
    busyVec[SLOT_SEC] |=> $stable(post.secVal));
endmodule

// File: rtl/rtc_time_dp.sv
module rtc_time_dp
  import rtc_pkg::*;
#(
  parameter int SUB_W = 16,
  parameter int SEC_W = 32,
  parameter int DIV   = 32768
) (
  input  logic      tclk,
  input  logic      trstn,
  input  postBus_t  post,
  output timeView_t tkView
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(DIV - 1);

  logic [NUM_WR-1:0] reqS1, reqS2, reqS3, strobe;
  logic [SUB_W-1:0]  subCnt, subAlm, subNext;
  logic [SEC_W-1:0]  secCnt, secAlm, secNext;
  logic [3:0]        ctrl;
  logic [1:0]        intStat;
  logic              irqR;
  logic              subStep, subWrap, secStep;
  logic              unusedPost;

  assign strobe  = reqS2 ^ reqS3;
  assign subStep = ctrl[0];
  assign subWrap = subStep && (subCnt == SUB_LAST);
  assign secStep = ctrl[1] && subWrap;
  assign subNext = subWrap ? '0 : subCnt + 1'b1;
  assign secNext = secCnt + 1'b1;
  assign unusedPost = ^{post.subAlm, post.secAlm, post.secVal};

  always_ff @(posedge tclk or negedge trstn) begin
    if (!trstn) begin
      reqS1   <= '0;
      reqS2   <= '0;
      reqS3   <= '0;
      subCnt  <= '0;
      secCnt  <= '0;
      subAlm  <= '0;
      secAlm  <= '0;
      ctrl    <= '0;
      intStat <= '0;
      irqR    <= 1'b0;
    end else begin
      reqS1 <= post.reqTog;
      reqS2 <= reqS1;
      reqS3 <= reqS2;

      if (strobe[SLOT_SUB])
        subCnt <= (post.subVal >= 32'(DIV)) ? '0 : post.subVal[SUB_W-1:0];
      else if (subStep)
        subCnt <= subNext;

      if (strobe[SLOT_SEC])  secCnt <= post.secVal[SEC_W-1:0];
      else if (secStep)      secCnt <= secNext;

      if (strobe[SLOT_SUBALM]) subAlm <= post.subAlm[SUB_W-1:0];
      if (strobe[SLOT_SECALM]) secAlm <= post.secAlm[SEC_W-1:0];
      if (strobe[SLOT_CTRL])   ctrl   <= post.ctrl;

      if (subStep && !strobe[SLOT_SUB] && subNext == subAlm) intStat[0] <= 1'b1;
      else if (strobe[SLOT_CLRSUB])                          intStat[0] <= 1'b0;
      if (secStep && !strobe[SLOT_SEC] && secNext == secAlm) intStat[1] <= 1'b1;
      else if (strobe[SLOT_CLRSEC])                          intStat[1] <= 1'b0;

      irqR <= |(intStat & ctrl[3:2]);
    end
  end

  assign tkView.ackTog  = reqS3;
  assign tkView.subCnt  = DATA_W'(subCnt);
  assign tkView.secCnt  = DATA_W'(secCnt);
  assign tkView.intStat = intStat;
  assign tkView.irq     = irqR;

  // R2: a disabled sub-second counter with no write landing keeps its value
  p_hold_when_off_r2: assert property (@(posedge tclk) disable iff (!trstn)
    (!ctrl[0] && !strobe[SLOT_SUB]) |=> $stable(subCnt));

  // R6: the wrap returns to zero and carries one into the seconds counter
  p_wrap_carry_r6: assert property (@(posedge tclk) disable iff (!trstn)
    (ctrl[0] && ctrl[1] && subCnt == SUB_LAST && strobe[SLOT_SEC:SLOT_SUB] == 2'b00)
    |=> (subCnt == '0 && secCnt == SEC_W'($past(secCnt) + 1'b1)));

  // R7: stepping onto the seconds alarm marks the seconds status bit
  p_alarm_hit_r7: assert property (@(posedge tclk) disable iff (!trstn)
    (secStep && !strobe[SLOT_SEC] && secCnt + 1'b1 == secAlm) |=> intStat[1]);
endmodule

// File: rtl/slow_rtc.sv
module slow_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SUB_W  = 16,
  parameter int SEC_W  = 32,
  parameter int DIV    = 32768
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              tclk,
  input  logic              trstn,
  output logic              irq
);
  postBus_t  post;
  timeView_t tkView;

  rtc_bus_ctrl #(.ADDR_W(ADDR_W)) busSide (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .tkView(tkView), .post(post), .irq(irq)
  );

  rtc_time_dp #(.SUB_W(SUB_W), .SEC_W(SEC_W), .DIV(DIV)) timeSide (
    .tclk(tclk), .trstn(trstn), .post(post), .tkView(tkView)
  );
endmodule

// File: tb/slow_rtc_test.sv
module slow_rtc_test;
  logic        pclk = 0, tclk = 0;
  logic        presetn = 0, trstn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // model state kept by the bench
  int expSubAlm = 0, expSecAlm = 0, expCtrl = 0;

  slow_rtc #(.ADDR_W(5), .SUB_W(16), .SEC_W(32), .DIV(8)) uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .tclk(tclk), .trstn(trstn), .irq(irq)
  );

  always #4  pclk = ~pclk;   // 125 MHz
  always #12 tclk = ~tclk;

  always @(posedge pclk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic apbWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    d = prdata;
    psel = 0; penable = 0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      apbRead(5'h14, s);
      if (s[3] == 1'b0) break;
    end
    repeat (12) @(negedge pclk);
  endtask

  initial begin
    logic [31:0] d, d2;
    repeat (5) @(negedge pclk);
    presetn = 1; trstn = 1;
    repeat (5) @(negedge pclk);

    // R1 / R11: reset contents at every defined offset
    for (int a = 0; a <= 'h18; a += 4) begin
      apbRead(5'(a), d);
      check("R1", d, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R3 / R4: posted write, then a second write while busy
    apbWrite(5'h00, 32'd3);
    apbRead(5'h14, d);
    check("R3 busy sub", d & 32'h18, 32'h18);
    apbWrite(5'h00, 32'd6);
    apbRead(5'h14, d);
    check("R4 error flag", d & 32'h4, 32'h4);
    waitIdle();
    apbRead(5'h00, d);
    check("R4 dropped write", d, 32'd3);
    apbRead(5'h14, d);
    check("R3 busy cleared", (d >> 3) & 32'hFF, 32'd0);

    // R5: status write clears the error flag
    apbWrite(5'h14, 32'd0);
    apbRead(5'h14, d);
    check("R5 error cleared", d & 32'h4, 32'd0);

    // R6: out-of-range sub-second load
    apbWrite(5'h00, 32'd20);
    waitIdle();
    apbRead(5'h00, d);
    check("R6 clamp", d, 32'd0);

    // R2: seconds counter holds while disabled
    apbWrite(5'h04, 32'd7);
    waitIdle();
    apbRead(5'h04, d);
    check("R11 sec", d, 32'd7);
    repeat (100) @(negedge pclk);
    apbRead(5'h04, d);
    check("R2 hold", d, 32'd7);

    // R3: two different registers in flight at once, busy bit order
    expSubAlm = 5; expSecAlm = 8;
    apbWrite(5'h08, expSubAlm);
    apbWrite(5'h0C, expSecAlm);
    apbRead(5'h14, d);
    check("R3 alarm busy bits", d & 32'hC8, 32'hC8);
    waitIdle();
    apbRead(5'h08, d);
    check("R11 sub alarm", d, expSubAlm);
    apbRead(5'h0C, d);
    check("R11 sec alarm", d, expSecAlm);

    // R10: undefined offset
    apbWrite(5'h1C, 32'hF);
    apbRead(5'h14, d);
    check("R10 no busy", d & 32'h7F8, 32'd0);
    apbRead(5'h1C, d);
    check("R10 read zero", d, 32'd0);
    apbRead(5'h08, d);
    check("R10 alarm intact", d, expSubAlm);

    // R7 / R8: sub-second alarm with only sub counting
    expCtrl = 5;
    apbWrite(5'h10, expCtrl);
    apbRead(5'h10, d);
    check("R11 ctrl", d, expCtrl);
    for (int k = 0; k < 500 && !irq; k++) @(negedge pclk);
    check("R8 irq from sub alarm", {31'd0, irq}, 32'd1);
    apbRead(5'h14, d);
    check("R7 sub status", d & 32'h1, 32'h1);
    repeat (200) @(negedge pclk);
    apbRead(5'h04, d);
    check("R2 sec held while off", d, 32'd7);

    // R6 / R7: count both, sub wraps carry seconds past alarm 8
    apbWrite(5'h10, 32'h7);
    waitIdle();
    repeat (100) @(negedge pclk);
    apbWrite(5'h10, 32'h4);
    waitIdle();
    apbRead(5'h14, d);
    check("R7 both status", d & 32'h3, 32'h3);
    apbRead(5'h04, d);
    check("R6 carry", {31'd0, (d >= 9 && d <= 20)}, 32'd1);
    apbRead(5'h00, d);
    repeat (40) @(negedge pclk);
    apbRead(5'h00, d2);
    check("R2 sub held", d2, d);

    // R9: clearing
    apbWrite(5'h18, 32'h0);
    apbRead(5'h14, d);
    check("R9 zero posts nothing", d & 32'h608, 32'd0);
    apbWrite(5'h18, 32'h1);
    waitIdle();
    repeat (20) @(negedge pclk);
    apbRead(5'h14, d);
    check("R9 sub cleared", d & 32'h3, 32'h2);
    check("R8 sec int masked", {31'd0, irq}, 32'd0);
    apbRead(5'h18, d);
    check("R9 reads zero", d, 32'd0);

    apbWrite(5'h10, 32'hC);
    waitIdle();
    repeat (20) @(negedge pclk);
    check("R8 sec int enabled", {31'd0, irq}, 32'd1);
    apbWrite(5'h18, 32'h2);
    waitIdle();
    repeat (20) @(negedge pclk);
    check("R9 irq after sec clear", {31'd0, irq}, 32'd0);
    apbRead(5'h14, d);
    check("R9 status clean", d & 32'h7FF, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule